// File: doc/BRIEF.md
# ADC Sample-and-Convert Sequencer

This block is the digital side of a 10-bit successive-approximation converter. It divides the system clock into a TAD conversion-clock enable and runs each sample in two phases. During acquisition it holds the sample/hold switch closed on the selected analog input. During conversion it opens the switch and works through the result bits one at a time, reading an external comparator against the trial code it puts on its DAC output. Each conversion lasts a fixed twelve TAD periods. Each finished code goes into a 16-entry result buffer. An optional interrupt fires once a programmable group of results has been stored.

Acquisition has two modes. In manual mode it follows a software sample bit. In automatic mode the hardware starts acquisition itself and ends it either after a programmed number of TADs or on an external trigger pulse. The input comes from one of two channel settings (A or B). The sequencer can alternate between them from one conversion to the next, or it can step the A setting through a mask of enabled inputs. The sample/hold, DAC and comparator are outside the block.

Top module: `adc_seq_top`

## Requirements
- R1: During and after reset, with both modes off, `shConnect`, `resultStrobe` and `irq` are 0, `resultIdx` is 0 and `chanSel` equals `chSelA`.
- R2: The result register resolves bits from bit 9 down to bit 0. A bit stays set when `cmpIn` is 1 (held input at or above `dacCode`) and is cleared otherwise. The stored code therefore equals the held input level, including the extremes 0 and 1023.
- R3: Each `resultStrobe` rises exactly 12 × (`tadDiv`+1) clocks after `shConnect` falls. The TAD divider restarts when a phase begins.
- R4: When `autoMode`=1 and `trigSel`=0, `shConnect` stays high for exactly `acqCount` × (`tadDiv`+1) clocks, and a new acquisition starts without software action.
- R5: An `acqCount` of 0 gives the same acquisition length as 1.
- R6: When `autoMode`=0, `shConnect` rises the cycle after `sampleBit` is set and stays high while the bit stays set. Clearing the bit starts the conversion. No new acquisition starts while the bit stays clear.
- R7: When `autoMode`=1 and `trigSel`=1, acquisition continues until a one-cycle `extTrig` pulse, and the conversion follows that pulse.
- R8: When `altEn`=1, successive conversions use `chSelA`, `chSelB`, `chSelA`, … starting from A after reset.
- R9: When `scanEn`=1, the A-side conversions use the inputs whose `scanMask` bit is set, in ascending order, wrapping from the highest back to the lowest. The first conversion after reset uses the lowest set bit.
- R10: `resultIdx` counts 0, 1, … `convPerInt` and then returns to 0, so a group is `convPerInt`+1 results (1 to 16).
- R11: `irq` pulses together with `resultStrobe` for the result stored at index `convPerInt`, only when `irqEn`=1, and at no other time.
- R12: `rdData` returns the code stored at buffer entry `rdAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tadDiv | input | 8 | TAD period is tadDiv+1 clocks |
| autoMode | input | 1 | 1: hardware starts acquisition |
| sampleBit | input | 1 | Software sample control bit (manual mode) |
| acqCount | input | 5 | Auto acquisition length in TADs (0 means 1) |
| trigSel | input | 1 | Auto mode end of acquisition: 0 count, 1 extTrig |
| extTrig | input | 1 | External conversion trigger pulse |
| chSelA | input | 4 | Channel setting A |
| chSelB | input | 4 | Channel setting B |
| altEn | input | 1 | Alternate A/B per conversion |
| scanEn | input | 1 | Scan the A setting through scanMask |
| scanMask | input | 16 | Inputs enabled for scanning |
| convPerInt | input | 4 | Results per group minus one |
| irqEn | input | 1 | Completion interrupt enable |
| cmpIn | input | 1 | Comparator: held input >= dacCode |
| rdAddr | input | 4 | Buffer read address |
| shConnect | output | 1 | Sample/hold connected to input |
| chanSel | output | 4 | Selected analog input |
| dacCode | output | 10 | Trial code for the DAC |
| resultStrobe | output | 1 | One-cycle pulse when a result is stored |
| resultIdx | output | 4 | Buffer entry of the stored result |
| resultVal | output | 10 | Stored code |
| irq | output | 1 | Group-complete interrupt pulse |
| rdData | output | 10 | Buffer contents at rdAddr |

## Verification
The storing of a result can coincide with the buffer index wrapping, the interrupt firing, the scan pointer advancing and the A/B selection toggling, all on one write strobe. The bench provokes this with a group length of one (`convPerInt`=0) while scan and alternation are both active, so that every result wraps the index, raises the interrupt and switches the channel at once. A scoreboard computes the channel order and the expected index, code and interrupt per result independently. It also times each conversion and acquisition from the sample/hold strobe, so a result written with a stale channel or a misplaced interrupt shows up as a mismatch on that exact result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearSar;  // start a new approximation
    logic stepBit;   // resolve the current trial bit
    logic writeRes;  // store the finished code and advance
  } dpCmd_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int ACQ_W = 5,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] tadDiv,
  input  logic             autoMode,
  input  logic             sampleBit,
  input  logic [ACQ_W-1:0] acqCount,
  input  logic             trigSel,
  input  logic             extTrig,
  output logic             shConnect,
  output dpCmd_t           cmd
);

  localparam int CONV_TADS = RES_W + 2;
  localparam int CONV_W    = $clog2(CONV_TADS);
  localparam int SEQ_W     = (ACQ_W > CONV_W) ? ACQ_W : CONV_W;

  seqState_t        state, nextState;
  logic [DIV_W-1:0] tadCnt;
  logic             tick;
  logic [SEQ_W-1:0] seqCnt;
  logic [ACQ_W-1:0] acqTarget;
  logic             leaving;

  assign tick      = (tadCnt == tadDiv);
  assign acqTarget = (acqCount == '0) ? ACQ_W'(1) : acqCount;
  assign leaving   = (nextState != state);
  assign shConnect = (state == ST_ACQ);

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE: begin
        if (autoMode || sampleBit) nextState = ST_ACQ;
      end
      ST_ACQ: begin
        if (!autoMode) begin
          if (!sampleBit) nextState = ST_CONV;
        end else if (trigSel) begin
          if (extTrig) nextState = ST_CONV;
        end else if (tick && (seqCnt == SEQ_W'(acqTarget - ACQ_W'(1)))) begin
          nextState = ST_CONV;
        end
        cmd.clearSar = (nextState == ST_CONV);
      end
      ST_CONV: begin
        if (tick) begin
          cmd.stepBit = (seqCnt < SEQ_W'(RES_W));
          if (seqCnt == SEQ_W'(CONV_TADS - 1)) begin
            cmd.writeRes = 1'b1;
            nextState    = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tadCnt <= '0;
      seqCnt <= '0;
    end else begin
      state <= nextState;
      if (leaving || tick) tadCnt <= '0;
      else                 tadCnt <= tadCnt + 1'b1;
      if (leaving)   seqCnt <= '0;
      else if (tick) seqCnt <= seqCnt + 1'b1;
    end
  end

  // R5
  acq_tick_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && $past(state) == ST_ACQ && $past(autoMode) && !$past(trigSel))
      |-> $past(tick));

  // R6
  manual_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACQ && !autoMode && sampleBit) |=> (state == ST_ACQ));

  // R7
  trig_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACQ && autoMode && trigSel && !extTrig) |=> (state == ST_ACQ));

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int NCH   = 16,
  parameter int DEPTH = 16,
  parameter int CH_W  = $clog2(NCH),
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic             cmpIn,
  input  logic [CH_W-1:0]  chSelA,
  input  logic [CH_W-1:0]  chSelB,
  input  logic             altEn,
  input  logic             scanEn,
  input  logic [NCH-1:0]   scanMask,
  input  logic [PTR_W-1:0] convPerInt,
  input  logic             irqEn,
  input  logic [PTR_W-1:0] rdAddr,
  output logic [RES_W-1:0] dacCode,
  output logic [CH_W-1:0]  chanSel,
  output logic             resultStrobe,
  output logic [PTR_W-1:0] resultIdx,
  output logic [RES_W-1:0] resultVal,
  output logic             irq,
  output logic [RES_W-1:0] rdData
);

  localparam logic [RES_W-1:0] TOP_BIT = RES_W'(1) << (RES_W - 1);

  // ---------------- successive approximation ----------------
  logic [RES_W-1:0] sar, trialMask;

  assign dacCode = sar | trialMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sar       <= '0;
      trialMask <= '0;
    end else if (cmd.clearSar) begin
      sar       <= '0;
      trialMask <= TOP_BIT;
    end else if (cmd.stepBit) begin
      if (cmpIn) sar <= sar | trialMask;
      trialMask <= trialMask >> 1;
    end
  end

  // ---------------- channel selection ----------------
  function automatic logic [CH_W-1:0] nextOn(input logic [CH_W-1:0] p,
                                              input logic [NCH-1:0]  m);
    logic found;
    logic [CH_W-1:0] cand;
    nextOn = p;
    found  = 1'b0;
    for (int i = 1; i <= NCH; i++) begin
      cand = CH_W'((int'(p) + i) % NCH);
      if (!found && m[cand]) begin
        nextOn = cand;
        found  = 1'b1;
      end
    end
  endfunction

  logic            useB;
  logic [CH_W-1:0] scanCur, scanA, selA;
  logic            onB;

  assign scanA   = scanMask[scanCur] ? scanCur : nextOn(scanCur, scanMask);
  assign selA    = scanEn ? scanA : chSelA;
  assign onB     = altEn && useB;
  assign chanSel = onB ? chSelB : selA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      useB    <= 1'b0;
      scanCur <= '0;
    end else if (cmd.writeRes) begin
      useB <= altEn ? !useB : 1'b0;
      if (scanEn && !onB) scanCur <= nextOn(scanA, scanMask);
    end
  end

  // ---------------- result buffer ----------------
  logic [RES_W-1:0] resBuf [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic             groupEnd;

  assign groupEnd = (wrPtr == convPerInt);
  assign rdData   = resBuf[rdAddr];

  always_ff @(posedge clk) begin
    if (cmd.writeRes) resBuf[wrPtr] <= sar;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr        <= '0;
      resultStrobe <= 1'b0;
      resultIdx    <= '0;
      resultVal    <= '0;
      irq          <= 1'b0;
    end else begin
      resultStrobe <= cmd.writeRes;
      irq          <= cmd.writeRes && irqEn && groupEnd;
      if (cmd.writeRes) begin
        resultIdx <= wrPtr;
        resultVal <= sar;
        wrPtr     <= groupEnd ? '0 : wrPtr + 1'b1;
      end
    end
  end

  // R2
  step_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stepBit |-> (trialMask != '0));

  // R2
  write_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.writeRes |-> (trialMask == '0));

  // R2
  trial_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trialMask));

  // R10
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.writeRes |=> (wrPtr == '0 || wrPtr == $past(wrPtr) + 1'b1));

  // R11
  irq_group_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (resultStrobe && resultIdx == convPerInt));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int NCH   = 16,
  parameter int DEPTH = 16,
  parameter int DIV_W = 8,
  parameter int ACQ_W = 5,
  parameter int CH_W  = $clog2(NCH),
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] tadDiv,
  input  logic             autoMode,
  input  logic             sampleBit,
  input  logic [ACQ_W-1:0] acqCount,
  input  logic             trigSel,
  input  logic             extTrig,
  input  logic [CH_W-1:0]  chSelA,
  input  logic [CH_W-1:0]  chSelB,
  input  logic             altEn,
  input  logic             scanEn,
  input  logic [NCH-1:0]   scanMask,
  input  logic [PTR_W-1:0] convPerInt,
  input  logic             irqEn,
  input  logic             cmpIn,
  input  logic [PTR_W-1:0] rdAddr,
  output logic             shConnect,
  output logic [CH_W-1:0]  chanSel,
  output logic [RES_W-1:0] dacCode,
  output logic             resultStrobe,
  output logic [PTR_W-1:0] resultIdx,
  output logic [RES_W-1:0] resultVal,
  output logic             irq,
  output logic [RES_W-1:0] rdData
);

  dpCmd_t cmd;

  adc_seq_ctrl #(
    .DIV_W(DIV_W), .ACQ_W(ACQ_W), .RES_W(RES_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tadDiv(tadDiv), .autoMode(autoMode),
    .sampleBit(sampleBit), .acqCount(acqCount), .trigSel(trigSel),
    .extTrig(extTrig), .shConnect(shConnect), .cmd(cmd)
  );

  adc_seq_dp #(
    .RES_W(RES_W), .NCH(NCH), .DEPTH(DEPTH), .CH_W(CH_W), .PTR_W(PTR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cmpIn(cmpIn),
    .chSelA(chSelA), .chSelB(chSelB), .altEn(altEn), .scanEn(scanEn),
    .scanMask(scanMask), .convPerInt(convPerInt), .irqEn(irqEn),
    .rdAddr(rdAddr), .dacCode(dacCode), .chanSel(chanSel),
    .resultStrobe(resultStrobe), .resultIdx(resultIdx),
    .resultVal(resultVal), .irq(irq), .rdData(rdData)
  );

endmodule

// File: tb/adc_seq_top_test.sv
module adc_seq_top_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] tadDiv = 8'd0;
  logic       autoMode = 1'b0, sampleBit = 1'b0, trigSel = 1'b0, extTrig = 1'b0;
  logic [4:0] acqCount = 5'd0;
  logic [3:0] chSelA = 4'd0, chSelB = 4'd0;
  logic       altEn = 1'b0, scanEn = 1'b0, irqEn = 1'b0;
  logic [15:0] scanMask = 16'h0;
  logic [3:0] convPerInt = 4'd15;
  logic       cmpIn;
  logic [3:0] rdAddr = 4'd0;
  logic       shConnect, resultStrobe, irq;
  logic [3:0] chanSel, resultIdx;
  logic [9:0] dacCode, resultVal, rdData;

  adc_seq_top uut (
    .clk(clk), .rstN(rstN), .tadDiv(tadDiv), .autoMode(autoMode),
    .sampleBit(sampleBit), .acqCount(acqCount), .trigSel(trigSel),
    .extTrig(extTrig), .chSelA(chSelA), .chSelB(chSelB), .altEn(altEn),
    .scanEn(scanEn), .scanMask(scanMask), .convPerInt(convPerInt),
    .irqEn(irqEn), .cmpIn(cmpIn), .rdAddr(rdAddr), .shConnect(shConnect),
    .chanSel(chanSel), .dacCode(dacCode), .resultStrobe(resultStrobe),
    .resultIdx(resultIdx), .resultVal(resultVal), .irq(irq), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Analog model: per-channel levels, sample/hold, comparator
  logic [9:0] chanV [16];
  logic [9:0] held = 10'd0;
  always @(posedge clk) if (shConnect) held <= chanV[chanSel];
  assign cmpIn = (held >= dacCode);

  int nChecks = 0, nFail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard
  typedef struct {
    int    idx;
    int    val;
    bit    irqExp;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  bit     acqCheckOn = 1'b0;
  longint acqExp = 0;
  string  acqTag = "R4";

  // Monitor: timing of phases and popped results
  bit     prevSh = 1'b0, riseOk = 1'b0, fallOk = 1'b0;
  longint riseT = 0, fallT = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      prevSh = 1'b0; riseOk = 1'b0; fallOk = 1'b0;
    end else begin
      if (shConnect && !prevSh) begin
        riseT = cyc; riseOk = 1'b1;
      end
      if (!shConnect && prevSh) begin
        fallT = cyc; fallOk = riseOk;
        if (acqCheckOn && riseOk)
          check((cyc - riseT) == acqExp, acqTag, "acquisition clocks", cyc - riseT, acqExp);
      end
      if (irq && !resultStrobe) check(1'b0, "R11", "irq without result", 1, 0);
      if (resultStrobe) begin
        if (fallOk)
          check((cyc - fallT) == 12 * (int'(tadDiv) + 1), "R3", "conversion clocks",
                cyc - fallT, 12 * (int'(tadDiv) + 1));
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "unexpected result", resultVal, -1);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(int'(resultVal) == e.val, e.tag, "result code", resultVal, e.val);
          check(int'(resultIdx) == e.idx, "R10", "buffer index", resultIdx, e.idx);
          check(irq == e.irqExp, "R11", "interrupt", irq, e.irqExp);
        end
      end
      prevSh = shConnect;
    end
  end

  // Driver: expected sequence from the requirements
  task automatic pushRun(input int n, input string tag);
    int  scanP = 0;
    bit  useB = 1'b0;
    for (int k = 0; k < n; k++) begin
      int ch;
      expItem_t e;
      if (altEn && useB) begin
        ch = chSelB;
      end else if (scanEn) begin
        ch = scanP;
        for (int j = 0; j < 16; j++) begin
          if (scanMask[(scanP + j) % 16]) begin
            ch = (scanP + j) % 16;
            break;
          end
        end
        scanP = (ch + 1) % 16;
      end else begin
        ch = chSelA;
      end
      if (altEn) useB = !useB;
      e.idx    = k % (int'(convPerInt) + 1);
      e.val    = chanV[ch];
      e.irqExp = irqEn && (e.idx == int'(convPerInt));
      e.tag    = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  task automatic enterReset();
    @(posedge clk); #1;
    rstN = 1'b0;
    autoMode = 1'b0; sampleBit = 1'b0; trigSel = 1'b0; extTrig = 1'b0;
    altEn = 1'b0; scanEn = 1'b0; irqEn = 1'b0; convPerInt = 4'd15;
    acqCheckOn = 1'b0;
  endtask

  task automatic leaveReset();
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic manualOne(input int ch, input int k, input string tag);
    expItem_t e;
    bit stayed = 1'b1;
    chSelA = 4'(ch);
    e.idx = k; e.val = chanV[ch]; e.irqExp = 1'b0; e.tag = tag;
    expQ.push_back(e);
    @(posedge clk); #1 sampleBit = 1'b1;
    @(posedge clk); @(negedge clk);
    check(shConnect == 1'b1, "R6", "acquire after set", shConnect, 1);
    repeat (10) begin
      @(negedge clk);
      if (!shConnect) stayed = 1'b0;
    end
    check(stayed, "R6", "held while set", stayed, 1);
    @(posedge clk); #1 sampleBit = 1'b0;
    drain();
  endtask

  // Watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog R1..all actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) chanV[i] = 10'((i * 61 + 17) % 1024);
    chanV[0]  = 10'd0;
    chanV[15] = 10'd1023;

    // ---- reset state (R1)
    chSelA = 4'd6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!shConnect && !resultStrobe && !irq, "R1", "outputs in reset",
          {shConnect, resultStrobe, irq}, 0);
    #1 rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!shConnect && !resultStrobe && !irq, "R1", "outputs after reset",
          {shConnect, resultStrobe, irq}, 0);
    check(resultIdx == 4'd0, "R1", "index after reset", resultIdx, 0);
    check(chanSel == chSelA, "R1", "channel after reset", chanSel, chSelA);

    // ---- manual mode (R6, R2, R3, R12)
    tadDiv = 8'd2; irqEn = 1'b1;
    manualOne(5, 0, "R2");
    manualOne(0, 1, "R2");
    manualOne(15, 2, "R2");
    begin
      bit quiet = 1'b1;
      repeat (50) begin
        @(negedge clk);
        if (shConnect) quiet = 1'b0;
      end
      check(quiet, "R6", "no acquisition while bit clear", quiet, 1);
    end
    rdAddr = 4'd0; #1;
    check(rdData == chanV[5], "R12", "readback 0", rdData, chanV[5]);
    rdAddr = 4'd1; #1;
    check(rdData == chanV[0], "R12", "readback 1", rdData, chanV[0]);
    rdAddr = 4'd2; #1;
    check(rdData == chanV[15], "R12", "readback 2", rdData, chanV[15]);

    // ---- automatic, counted acquisition (R4)
    enterReset();
    tadDiv = 8'd1; acqCount = 5'd3; chSelA = 4'd9; autoMode = 1'b1;
    acqExp = 3 * 2; acqTag = "R4"; acqCheckOn = 1'b1;
    pushRun(4, "R4");
    leaveReset();
    drain();

    // ---- zero count treated as one (R5)
    enterReset();
    tadDiv = 8'd3; acqCount = 5'd0; chSelA = 4'd15; autoMode = 1'b1;
    acqExp = 1 * 4; acqTag = "R5"; acqCheckOn = 1'b1;
    pushRun(3, "R5");
    leaveReset();
    drain();

    // ---- external trigger (R7)
    enterReset();
    tadDiv = 8'd1; acqCount = 5'd2; chSelA = 4'd4; autoMode = 1'b1; trigSel = 1'b1;
    pushRun(2, "R7");
    leaveReset();
    for (int t = 0; t < 2; t++) begin
      bit high = 1'b1;
      while (!shConnect) @(negedge clk);
      repeat (40) begin
        @(negedge clk);
        if (!shConnect) high = 1'b0;
      end
      check(high, "R7", "waits for trigger", high, 1);
      @(posedge clk); #1 extTrig = 1'b1;
      @(posedge clk); #1 extTrig = 1'b0;
      while (expQ.size() > 1 - t) @(negedge clk);
    end
    drain();

    // ---- alternation, group of four with interrupt (R8, R10, R11)
    enterReset();
    tadDiv = 8'd1; acqCount = 5'd2; chSelA = 4'd3; chSelB = 4'd12;
    altEn = 1'b1; autoMode = 1'b1; convPerInt = 4'd3; irqEn = 1'b1;
    acqExp = 2 * 2; acqTag = "R4"; acqCheckOn = 1'b1;
    pushRun(6, "R8");
    leaveReset();
    drain();

    // ---- scan, group of five, interrupt disabled (R9, R10, R11)
    enterReset();
    tadDiv = 8'd0; acqCount = 5'd1; scanMask = 16'h8425; scanEn = 1'b1;
    autoMode = 1'b1; convPerInt = 4'd4; irqEn = 1'b0;
    acqExp = 1; acqTag = "R4"; acqCheckOn = 1'b1;
    pushRun(7, "R9");
    leaveReset();
    drain();

    // ---- scan with alternation, every result ends a group (R8, R9, R10, R11)
    enterReset();
    tadDiv = 8'd1; acqCount = 5'd2; scanMask = 16'h0222; chSelB = 4'd7;
    scanEn = 1'b1; altEn = 1'b1; autoMode = 1'b1; convPerInt = 4'd0; irqEn = 1'b1;
    acqExp = 2 * 2; acqTag = "R4"; acqCheckOn = 1'b1;
    pushRun(8, "R9");
    leaveReset();
    drain();
    enterReset();
    leaveReset();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule